// File: doc/BRIEF.md
# Case-Converting Text Buffer Engine

This block is a small text accelerator that a host reaches through two address windows on a shared address space. The first window is one byte wide and holds the operation-select register. The second window is 256 bytes wide and exposes a text buffer, which the host fills with bytes and later reads back. The two base addresses are inputs, so a surrounding bus fabric or configuration block decides where the windows sit.

To start a conversion, the host commits a region by giving an address inside the buffer window and a length. The engine clamps the length so that it never runs past the end of the buffer. It then steps through the region one byte per clock. On each step it reads a byte, applies the selected case transform and writes the result back in place. When the walk ends, the engine raises a one-cycle done pulse. While the walk runs, host bus accesses are stalled.

Top module: `caseconv_top`

## Requirements
- R1: An address hits a window when it is at or above that window's base and below base plus size. The I/O window is 1 byte and the buffer window is 256 bytes. The offset is the address minus the base. The I/O window is checked first. `busHit` bit 0 flags an I/O hit and bit 1 a buffer hit. On a miss, `busHit` is 0 and `busRdata` equals `busRdataIn`.
- R2: A bus write to I/O offset 0 stores `busWdata` as the new operation code.
- R3: A bus read of I/O offset 0 returns the operation code in bits [7:0] and `busRdataIn[31:8]` in the upper bits.
- R4: A bus write inside the buffer window stores `busWdata` at that offset. A read returns the byte in bits [7:0], with zeros above.
- R5: Operation 0 maps 0x41..0x5A to lowercase by setting bit 5.
- R6: Operation 1 maps 0x61..0x7A to uppercase by clearing bit 5.
- R7: Operation 2 turns uppercase letters to lowercase and lowercase letters to uppercase.
- R8: An operation code of 3 or more leaves every byte unchanged. Under every operation, bytes that are not ASCII letters are unchanged.
- R9: A commit pulse in idle converts the bytes from the commit offset for the clamped length n, one byte per cycle, and leaves all other bytes untouched. `done` is high for exactly one cycle, n+1 cycles after the commit edge.
- R10: The clamped length is min(`commitLen`, 256 - offset). A commit address outside the buffer window gives n = 0, so no byte changes and `done` follows in the next cycle.
- R11: While a walk is running, `busy` and `busStall` are 1, and bus writes to the operation register and to the buffer have no effect.
- R12: After reset, the operation code is 0, every buffer byte is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioBase | input | 32 | Base address of the 1-byte operation window |
| memBase | input | 32 | Base address of the 256-byte buffer window |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Bus address |
| busWdata | input | 8 | Write byte |
| busRdataIn | input | 32 | Value already on the read bus |
| busRdata | output | 32 | Read result |
| busHit | output | 2 | bit0 I/O window hit, bit1 buffer window hit |
| busStall | output | 1 | Access held off during a walk |
| commitValid | input | 1 | Start a conversion walk |
| commitAddr | input | 32 | Start address, inside the buffer window |
| commitLen | input | 9 | Requested byte count |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Some properties are checked every cycle. The done pulse never lasts more than one cycle. A commit with zero clamped length goes straight to done. The walk position plus the remaining count never passes the buffer end. The operation code stays frozen during a walk. Under operation 1 a converted byte is never a lowercase letter, and under an opaque operation code a written byte keeps its value. Other behaviours only show up in the bench's scenarios against a byte-accurate model. These are the exact transform of each operation, the untouched bytes outside the region, the done latency, the effect of window base placement and the read bus passthrough.

// File: rtl/caseconv_pkg.sv
package caseconv_pkg;
  parameter int unsigned CC_ADDR_W    = 32;
  parameter int unsigned CC_BUF_BYTES = 256;
  parameter int unsigned CC_IO_BYTES  = 1;
  localparam int unsigned CC_IDX_W    = $clog2(CC_BUF_BYTES);
  localparam int unsigned CC_LEN_W    = CC_IDX_W + 1;
  localparam int unsigned CC_IO_OFF_W = (CC_IO_BYTES > 1) ? $clog2(CC_IO_BYTES) : 1;

  localparam logic [7:0] OP_LOWER = 8'd0;
  localparam logic [7:0] OP_UPPER = 8'd1;
  localparam logic [7:0] OP_FLIP  = 8'd2;

  typedef struct packed {
    logic                busy;
    logic                walkWr;
    logic [CC_IDX_W-1:0] walkIdx;
  } ctlStrobe_t;

  function automatic logic isUpperCh(input logic [7:0] b);
    return (b >= 8'h41) && (b <= 8'h5A);
  endfunction

  function automatic logic isLowerCh(input logic [7:0] b);
    return (b >= 8'h61) && (b <= 8'h7A);
  endfunction

  function automatic logic [7:0] caseXform(input logic [7:0] op, input logic [7:0] b);
    logic [7:0] r;
    r = b;
    case (op)
      OP_LOWER: if (isUpperCh(b)) r = b | 8'h20;
      OP_UPPER: if (isLowerCh(b)) r = b & 8'hDF;
      OP_FLIP:  if (isUpperCh(b) || isLowerCh(b)) r = b ^ 8'h20;
      default:  r = b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/caseconv_win.sv
module caseconv_win #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SIZE  = 256,
  parameter int unsigned OFF_W = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    base,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  logic [AW:0] diff;

  always_comb begin
    diff = {1'b0, addr} - {1'b0, base};
    hit  = (addr >= base) && (diff < (AW+1)'(SIZE));
    off  = diff[OFF_W-1:0];
  end
endmodule

// File: rtl/caseconv_ctrl.sv
module caseconv_ctrl
  import caseconv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commitValid,
  input  logic                commitHit,
  input  logic [CC_IDX_W-1:0] commitOff,
  input  logic [CC_LEN_W-1:0] commitLen,
  output ctlStrobe_t          ctl,
  output logic                done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} walkState_t;

  walkState_t          state;
  logic [CC_IDX_W-1:0] idx;
  logic [CC_LEN_W-1:0] remain;
  logic [CC_LEN_W-1:0] avail;
  logic [CC_LEN_W-1:0] clampLen;

  always_comb begin
    avail    = CC_LEN_W'(CC_BUF_BYTES) - {1'b0, commitOff};
    clampLen = '0;
    if (commitHit) clampLen = (commitLen < avail) ? commitLen : avail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (commitValid) begin
          idx    <= commitOff;
          remain <= clampLen;
          state  <= (clampLen == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          idx    <= idx + 1'b1;
          remain <= remain - 1'b1;
          if (remain == CC_LEN_W'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.busy    = (state == ST_RUN);
    ctl.walkWr  = (state == ST_RUN);
    ctl.walkIdx = idx;
    done        = (state == ST_DONE);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && commitValid && clampLen == '0) |=> done); // R10
  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.busy |-> (({2'b0, idx} + {1'b0, remain}) <= (CC_LEN_W+1)'(CC_BUF_BYTES))); // R10
endmodule

// File: rtl/caseconv_dp.sv
module caseconv_dp
  import caseconv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrobe_t          ctl,
  input  logic                hostWrOp,
  input  logic                hostWrMem,
  input  logic [CC_IDX_W-1:0] memOff,
  input  logic [7:0]          wdata,
  output logic [7:0]          opCode,
  output logic [7:0]          rdByte
);
  logic [7:0] textBuf [CC_BUF_BYTES];
  logic [7:0] opReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opReg <= OP_LOWER;
      for (int i = 0; i < int'(CC_BUF_BYTES); i++) textBuf[i] <= '0;
    end else if (ctl.walkWr) begin
      textBuf[ctl.walkIdx] <= caseXform(opReg, textBuf[ctl.walkIdx]);
    end else if (!ctl.busy) begin
      if (hostWrOp)  opReg <= wdata;
      if (hostWrMem) textBuf[memOff] <= wdata;
    end
  end

  assign opCode = opReg;
  assign rdByte = textBuf[memOff];

  AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.busy |=> $stable(opReg)); // R11
  AST_UPPER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.walkWr && opReg == OP_UPPER) |=> !isLowerCh(textBuf[$past(ctl.walkIdx)])); // R6
  AST_OPAQUE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.walkWr && opReg > OP_FLIP) |=> textBuf[$past(ctl.walkIdx)] == $past(textBuf[ctl.walkIdx])); // R8
endmodule

// File: rtl/caseconv_top.sv
module caseconv_top
  import caseconv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CC_ADDR_W-1:0] ioBase,
  input  logic [CC_ADDR_W-1:0] memBase,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [CC_ADDR_W-1:0] busAddr,
  input  logic [7:0]           busWdata,
  input  logic [31:0]          busRdataIn,
  output logic [31:0]          busRdata,
  output logic [1:0]           busHit,
  output logic                 busStall,
  input  logic                 commitValid,
  input  logic [CC_ADDR_W-1:0] commitAddr,
  input  logic [CC_LEN_W-1:0]  commitLen,
  output logic                 busy,
  output logic                 done
);
  logic                   ioHitRaw, memHitRaw, cmtHit;
  logic [CC_IO_OFF_W-1:0] ioOff;
  logic [CC_IDX_W-1:0]    memOff, cmtOff;
  logic                   ioSel, memSel;
  ctlStrobe_t             ctl;
  logic [7:0]             opCode, rdByte;

  caseconv_win #(.AW(CC_ADDR_W), .SIZE(CC_IO_BYTES), .OFF_W(CC_IO_OFF_W)) u_ioWin (
    .addr(busAddr), .base(ioBase), .hit(ioHitRaw), .off(ioOff));
  caseconv_win #(.AW(CC_ADDR_W), .SIZE(CC_BUF_BYTES), .OFF_W(CC_IDX_W)) u_memWin (
    .addr(busAddr), .base(memBase), .hit(memHitRaw), .off(memOff));
  caseconv_win #(.AW(CC_ADDR_W), .SIZE(CC_BUF_BYTES), .OFF_W(CC_IDX_W)) u_cmtWin (
    .addr(commitAddr), .base(memBase), .hit(cmtHit), .off(cmtOff));

  always_comb begin
    ioSel  = busValid && ioHitRaw;
    memSel = busValid && memHitRaw && !ioHitRaw;
  end

  caseconv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .commitValid(commitValid), .commitHit(cmtHit),
    .commitOff(cmtOff), .commitLen(commitLen), .ctl(ctl), .done(done));

  caseconv_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .hostWrOp(ioSel && busWrite && (ioOff == '0)),
    .hostWrMem(memSel && busWrite), .memOff(memOff), .wdata(busWdata),
    .opCode(opCode), .rdByte(rdByte));

  always_comb begin
    busHit   = {memSel, ioSel};
    busy     = ctl.busy;
    busStall = ctl.busy;
    busRdata = busRdataIn;
    if (ioSel && ioOff == '0) busRdata = {busRdataIn[31:8], opCode};
    else if (memSel)          busRdata = {24'b0, rdByte};
  end
endmodule

// File: tb/caseconv_top_tb.sv
module caseconv_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ioBase = 32'h0000_1000;
  logic [31:0] memBase = 32'h0000_2000;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [31:0] busRdataIn = 32'hA5C3_7E00;
  logic [31:0] busRdata;
  logic [1:0]  busHit;
  logic        busStall, commitValid = 1'b0, busy, done;
  logic [31:0] commitAddr = '0;
  logic [8:0]  commitLen = '0;

  int checks = 0, failures = 0;
  logic [7:0] model [256];
  logic [7:0] opModel;

  always #10 clk = ~clk;

  caseconv_top u_dut (.*);

  function automatic logic [7:0] refX(input logic [7:0] op, input logic [7:0] b);
    logic up, lo;
    up = b >= 8'h41 && b <= 8'h5A;
    lo = b >= 8'h61 && b <= 8'h7A;
    if (op == 0 && up) return b + 8'h20;
    if (op == 1 && lo) return b - 8'h20;
    if (op == 2 && up) return b + 8'h20;
    if (op == 2 && lo) return b - 8'h20;
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [31:0] a, output logic [31:0] d, output logic [1:0] h);
    @(negedge clk); busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata; h = busHit;
    busValid = 0;
  endtask

  task automatic setOp(input logic [7:0] op);
    busWr(ioBase, op); opModel = op;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d; logic [1:0] h; int bad;
    bad = -1;
    for (int i = 0; i < 256; i++) begin
      busRd(memBase + i, d, h);
      if (bad < 0 && d !== {24'b0, model[i]}) bad = i;
    end
    checks++;
    if (bad >= 0) begin
      failures++;
      busRd(memBase + bad, d, h);
      $display("FAIL %s byte %0d actual=%h expected=%h", req, bad, d[7:0], model[bad]);
    end
  endtask

  task automatic runCommit(input string req, input logic [31:0] a, input int len);
    int n, off, cnt;
    off = int'(a) - int'(memBase);
    n = 0;
    if (a >= memBase && off < 256) n = (len < 256 - off) ? len : 256 - off;
    @(negedge clk); commitValid = 1; commitAddr = a; commitLen = 9'(len);
    @(negedge clk); commitValid = 0;
    cnt = 1;
    while (!done && cnt < 600) begin @(negedge clk); cnt++; end
    chk({req, " done latency"}, cnt, n + 1);
    @(negedge clk);
    chk({req, " done one cycle"}, {31'b0, done}, 0);
    for (int i = 0; i < n; i++) model[off + i] = refX(opModel, model[off + i]);
  endtask

  task automatic fill(input int off, input int cnt, input bit rnd);
    for (int i = off; i < off + cnt && i < 256; i++) begin
      logic [7:0] b;
      b = rnd ? 8'($urandom_range(32, 126)) : 8'(8'h40 + (i % 60));
      busWr(memBase + i, b); model[i] = b;
    end
  endtask

  initial begin
    #3_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [1:0] h;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    opModel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 busy", {31'b0, busy}, 0);
    chk("R12 done", {31'b0, done}, 0);
    busRd(ioBase, d, h);
    chk("R12/R3 op after reset", d, {busRdataIn[31:8], 8'h00});
    checkAll("R12 buffer zero");
    // R1 windows and miss
    busRd(32'h0000_0500, d, h);
    chk("R1 miss rdata", d, busRdataIn);
    chk("R1 miss hit", {30'b0, h}, 0);
    busRd(ioBase + 1, d, h);
    chk("R1 io window upper bound", {30'b0, h}, 0);
    busRd(memBase + 255, d, h);
    chk("R1 mem last byte hit", {30'b0, h}, 2);
    busRd(memBase + 256, d, h);
    chk("R1 mem past end", {30'b0, h}, 0);
    busRd(memBase - 1, d, h);
    chk("R1 below mem base", {30'b0, h}, 0);
    // R2 R3 op register
    setOp(8'h02);
    busRd(ioBase, d, h);
    chk("R2/R3 op readback", d, {busRdataIn[31:8], 8'h02});
    chk("R1 io hit", {30'b0, h}, 1);
    // R4 byte write/read
    busWr(memBase + 7, 8'h9C); model[7] = 8'h9C;
    busRd(memBase + 7, d, h);
    chk("R4 byte readback", d, 32'h0000_009C);
    // R5..R8 directed full-alphabet sweeps over 64 bytes
    fill(0, 64, 0); setOp(0); runCommit("R5", memBase, 64); checkAll("R5 lowercase");
    fill(0, 64, 0); setOp(1); runCommit("R6", memBase, 64); checkAll("R6 uppercase");
    fill(0, 64, 0); setOp(2); runCommit("R7", memBase, 64); checkAll("R7 swap");
    fill(0, 64, 0); setOp(3); runCommit("R8", memBase, 64); checkAll("R8 opaque op");
    // R9 single byte and region isolation
    fill(100, 4, 1); setOp(2); runCommit("R9 one byte", memBase + 101, 1); checkAll("R9 isolation");
    // R10 clamp at end and misses
    fill(240, 16, 0); fill(0, 16, 0); setOp(1);
    runCommit("R10 clamp", memBase + 240, 64); checkAll("R10 clamp no wrap");
    runCommit("R10 miss", memBase + 300, 10); checkAll("R10 miss no change");
    runCommit("R10 zero len", memBase + 5, 0);
    // R11 stall during walk
    fill(0, 40, 0); setOp(2);
    @(negedge clk); commitValid = 1; commitAddr = memBase; commitLen = 9'd40;
    @(negedge clk); commitValid = 0;
    busValid = 1; busWrite = 1; busAddr = ioBase; busWdata = 8'h03;
    #1 chk("R11 stall high", {31'b0, busStall}, 1);
    @(negedge clk); busAddr = memBase + 100; busWdata = 8'h55;
    @(negedge clk); busValid = 0; busWrite = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 40; i++) model[i] = refX(8'h02, model[i]);
    busRd(ioBase, d, h);
    chk("R11 op write ignored", d[7:0], 8'h02);
    checkAll("R11 buffer write ignored");
    // random mix
    for (int it = 0; it < 30; it++) begin
      int o;
      o = $urandom_range(0, 255);
      fill(o, 20, 1);
      setOp(8'($urandom_range(0, 4)));
      runCommit("R9 random", memBase + $urandom_range(0, 290) - 10, $urandom_range(0, 300));
      checkAll("R9/R10 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule